// File: doc/BRIEF.md
# Masked Fault Interrupt Aggregator

This block gathers fault and warning events from a power subsystem and turns them into one active-low interrupt request for a host processor. Each source is qualified in its own way before it counts. The over-temperature flag counts directly. A switching-regulator current limit must persist for a number of consecutive switching cycles. A linear-regulator current limit must persist for longer than a number of microsecond ticks. The bypass-switch over-threshold flag counts only in bypass mode. No source counts until soft-start has finished.

A qualified event sets a sticky status bit. The bit stays set until software writes a 1 to it. The interrupt pin goes low only when the global interrupt enable is set and at least one sticky bit is set. Both the interrupt enable and the input-voltage status enable come up cleared after reset.

A second active-low output reports an input voltage outside its window. It has its own enable. The raw undervoltage and overvoltage status bits can be read back whether or not that output is enabled.

Top module: `fault_irq_hub`

## Requirements
- R1: While `softStartDone` is high, a high `overTemp` sets `faultStat[0]` at the next clock edge.
- R2: For switching regulator i, `faultStat[1+i]` is set one cycle after the edge that registers the 16th `swCycleStb[i]` strobe seen while `swLimit[i]` is continuously high. Any cycle with `swLimit[i]` low restarts the count from zero.
- R3: For linear regulator j, `faultStat[1+NUM_SW+j]` is set one cycle after the 17th `usTick` registered while `ldoLimit[j]` is continuously high, which means a hold of more than 16 us. A drop of the limit flag restarts the count.
- R4: `bypassOverTh` sets `faultStat[NUM_SRC-1]` only while `bypassMode` is high. With `bypassMode` low it has no effect.
- R5: While `softStartDone` is low, no status bit is set and every qualification count is held at zero.
- R6: A set status bit holds until a cycle in which the matching `clearWr` bit is high. If a new event and a clear arrive in the same cycle, the event wins.
- R7: `irqN` is low exactly when the interrupt enable (`cfgData[0]` as last written with `cfgWr`) is 1 and any `faultStat` bit is set. Otherwise it is high.
- R8: `vinUnderStat` and `vinOverStat` follow `vinUnder` and `vinOver` with one cycle of delay, whatever the mask setting.
- R9: `vinStatN` is low exactly when the voltage enable (`cfgData[1]` as last written) is 1 and either `vinUnderStat` or `vinOverStat` is set.
- R10: After reset, every status bit is 0, both enables are 0, and `irqN` and `vinStatN` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| softStartDone | input | 1 | High once soft-start has completed |
| overTemp | input | 1 | Die over-temperature flag |
| swLimit | input | NUM_SW | Switching-regulator current-limit flags |
| swCycleStb | input | NUM_SW | One pulse per switching cycle, per regulator |
| ldoLimit | input | NUM_LDO | Linear-regulator current-limit flags |
| usTick | input | 1 | One pulse per microsecond |
| bypassMode | input | 1 | High when the bypass switch is in use |
| bypassOverTh | input | 1 | Bypass switch current over threshold |
| vinUnder | input | 1 | Input undervoltage flag |
| vinOver | input | 1 | Input overvoltage flag |
| cfgWr | input | 1 | Enable register write strobe |
| cfgData | input | 2 | bit0 interrupt enable, bit1 voltage status enable |
| clearWr | input | NUM_SRC | Write-one-to-clear strobes for status bits |
| faultStat | output | NUM_SRC | Sticky status bits |
| irqN | output | 1 | Active-low interrupt request |
| vinStatN | output | 1 | Active-low input-voltage status |
| vinUnderStat | output | 1 | Real-time undervoltage status |
| vinOverStat | output | 1 | Real-time overvoltage status |

## Verification
The switching-regulator path gets two strobe trains: one of 15 strobes broken by a drop of the limit, and one of 16 unbroken strobes. Only the second may set the bit, which separates a consecutive count from an accumulating one. The linear path gets 16 and 17 ticks, which tests the "more than" boundary. Every source is also driven hard during soft-start. The bypass flag is raised with the mode both off and on. A clear and a new event are issued in the same cycle to show which one wins. The voltage flags are toggled with the enable off and then on, which separates the masked pin from the raw status bits.

// File: rtl/fault_irq_pkg.sv
package fault_irq_pkg;

  typedef struct packed {
    logic vinEn;
    logic irqEn;
  } cfg_t;

  typedef struct packed {
    logic under;
    logic over;
  } vinSample_t;

  function automatic int cntBits(input int limit);
    return $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/fault_qualifier.sv
module fault_qualifier #(
  parameter int NUM_SW    = 4,
  parameter int NUM_LDO   = 2,
  parameter int SW_CYCLES = 16,
  parameter int LDO_US    = 16,
  localparam int NUM_SRC  = NUM_SW + NUM_LDO + 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               softStartDone,
  input  logic               overTemp,
  input  logic [NUM_SW-1:0]  swLimit,
  input  logic [NUM_SW-1:0]  swCycleStb,
  input  logic [NUM_LDO-1:0] ldoLimit,
  input  logic               usTick,
  input  logic               bypassMode,
  input  logic               bypassOverTh,
  output logic [NUM_SRC-1:0] tripVec
);
  import fault_irq_pkg::*;

  localparam int SW_W  = cntBits(SW_CYCLES);
  localparam int LDO_W = cntBits(LDO_US + 1);
  localparam logic [SW_W-1:0]  SW_MAX  = SW_W'(SW_CYCLES);
  localparam logic [LDO_W-1:0] LDO_MAX = LDO_W'(LDO_US + 1);

  assign tripVec[0]         = overTemp & softStartDone;
  assign tripVec[NUM_SRC-1] = bypassOverTh & bypassMode & softStartDone;

  for (genvar i = 0; i < NUM_SW; i++) begin : g_sw
    logic [SW_W-1:0] cycCnt;
    logic armed;
    assign armed = swLimit[i] & softStartDone;
    always_ff @(posedge clk) begin
      if (!rstN || !armed) cycCnt <= '0;
      else if (swCycleStb[i] && cycCnt != SW_MAX) cycCnt <= cycCnt + 1'b1;
    end
    assign tripVec[1+i] = armed && (cycCnt == SW_MAX);
  end

  for (genvar j = 0; j < NUM_LDO; j++) begin : g_ldo
    logic [LDO_W-1:0] usCnt;
    logic armed;
    assign armed = ldoLimit[j] & softStartDone;
    always_ff @(posedge clk) begin
      if (!rstN || !armed) usCnt <= '0;
      else if (usTick && usCnt != LDO_MAX) usCnt <= usCnt + 1'b1;
    end
    assign tripVec[1+NUM_SW+j] = armed && (usCnt == LDO_MAX);
  end

endmodule

// File: rtl/fault_sticky.sv
module fault_sticky #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] tripVec,
  input  logic [NUM_SRC-1:0] clearWr,
  input  logic               cfgWr,
  input  logic [1:0]         cfgData,
  input  logic               vinUnder,
  input  logic               vinOver,
  output logic [NUM_SRC-1:0] faultStat,
  output logic               irqN,
  output logic               vinStatN,
  output logic               vinUnderStat,
  output logic               vinOverStat
);
  import fault_irq_pkg::*;

  cfg_t       cfgQ;
  vinSample_t vinQ;
  logic [NUM_SRC-1:0] stickyQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stickyQ <= '0;
      cfgQ    <= '0;
      vinQ    <= '0;
    end else begin
      stickyQ <= (stickyQ & ~clearWr) | tripVec;
      if (cfgWr) cfgQ <= cfg_t'(cfgData);
      vinQ.under <= vinUnder;
      vinQ.over  <= vinOver;
    end
  end

  assign faultStat    = stickyQ;
  assign irqN         = ~(cfgQ.irqEn & (|stickyQ));
  assign vinUnderStat = vinQ.under;
  assign vinOverStat  = vinQ.over;
  assign vinStatN     = ~(cfgQ.vinEn & (vinQ.under | vinQ.over));

endmodule

// File: rtl/fault_irq_hub.sv
module fault_irq_hub #(
  parameter int NUM_SW    = 4,
  parameter int NUM_LDO   = 2,
  parameter int SW_CYCLES = 16,
  parameter int LDO_US    = 16,
  localparam int NUM_SRC  = NUM_SW + NUM_LDO + 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               softStartDone,
  input  logic               overTemp,
  input  logic [NUM_SW-1:0]  swLimit,
  input  logic [NUM_SW-1:0]  swCycleStb,
  input  logic [NUM_LDO-1:0] ldoLimit,
  input  logic               usTick,
  input  logic               bypassMode,
  input  logic               bypassOverTh,
  input  logic               vinUnder,
  input  logic               vinOver,
  input  logic               cfgWr,
  input  logic [1:0]         cfgData,
  input  logic [NUM_SRC-1:0] clearWr,
  output logic [NUM_SRC-1:0] faultStat,
  output logic               irqN,
  output logic               vinStatN,
  output logic               vinUnderStat,
  output logic               vinOverStat
);

  logic [NUM_SRC-1:0] tripVec;

  fault_qualifier #(
    .NUM_SW(NUM_SW), .NUM_LDO(NUM_LDO),
    .SW_CYCLES(SW_CYCLES), .LDO_US(LDO_US)
  ) u_qual (
    .clk(clk), .rstN(rstN), .softStartDone(softStartDone),
    .overTemp(overTemp), .swLimit(swLimit), .swCycleStb(swCycleStb),
    .ldoLimit(ldoLimit), .usTick(usTick), .bypassMode(bypassMode),
    .bypassOverTh(bypassOverTh), .tripVec(tripVec)
  );

  fault_sticky #(.NUM_SRC(NUM_SRC)) u_dp (
    .clk(clk), .rstN(rstN), .tripVec(tripVec), .clearWr(clearWr),
    .cfgWr(cfgWr), .cfgData(cfgData), .vinUnder(vinUnder), .vinOver(vinOver),
    .faultStat(faultStat), .irqN(irqN), .vinStatN(vinStatN),
    .vinUnderStat(vinUnderStat), .vinOverStat(vinOverStat)
  );

endmodule

// File: rtl/fault_irq_hub_chk.sv
module fault_irq_hub_chk #(
  parameter int NUM_SRC = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               softStartDone,
  input logic               overTemp,
  input logic               vinUnder,
  input logic               cfgWr,
  input logic [1:0]         cfgData,
  input logic [NUM_SRC-1:0] clearWr,
  input logic [NUM_SRC-1:0] faultStat,
  input logic               irqN,
  input logic               vinUnderStat
);

  p_temp_sets_r1: assert property (@(posedge clk) disable iff (!rstN)
    (overTemp && softStartDone) |=> faultStat[0]);

  p_softstart_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!softStartDone && faultStat == '0) |=> faultStat == '0);

  p_sticky_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((faultStat & $past(faultStat & ~clearWr)) == $past(faultStat & ~clearWr)));

  p_mask_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWr && !cfgData[0]) |=> irqN);

  p_vin_track_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (vinUnderStat == $past(vinUnder)));

endmodule

bind fault_irq_hub fault_irq_hub_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rstN(rstN), .softStartDone(softStartDone), .overTemp(overTemp),
  .vinUnder(vinUnder), .cfgWr(cfgWr), .cfgData(cfgData), .clearWr(clearWr),
  .faultStat(faultStat), .irqN(irqN), .vinUnderStat(vinUnderStat)
);

// File: tb/fault_irq_hub_test.sv
module fault_irq_hub_test;
  localparam int NSW = 4, NLDO = 2, NSRC = NSW + NLDO + 2;
  localparam int LDO_BIT0 = 1 + NSW;

  logic clk = 0, rstN = 0;
  logic softStartDone = 0, overTemp = 0, usTick = 0;
  logic bypassMode = 0, bypassOverTh = 0, vinUnder = 0, vinOver = 0;
  logic cfgWr = 0;
  logic [1:0] cfgData = 0;
  logic [NSW-1:0] swLimit = 0, swCycleStb = 0;
  logic [NLDO-1:0] ldoLimit = 0;
  logic [NSRC-1:0] clearWr = 0;
  logic [NSRC-1:0] faultStat;
  logic irqN, vinStatN, vinUnderStat, vinOverStat;

  int checks = 0, fails = 0;
  bit finished = 0;

  // behavioural reference state
  int swCnt [NSW];
  int ldoCnt [NLDO];
  bit [NSRC-1:0] mSticky;
  bit mIrqEn, mVinEn, mUnder, mOver;

  always #10 clk = ~clk;

  fault_irq_hub uut (.*);

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (swCnt[i]) swCnt[i] = 0;
      foreach (ldoCnt[i]) ldoCnt[i] = 0;
      mSticky = 0; mIrqEn = 0; mVinEn = 0; mUnder = 0; mOver = 0;
    end else begin
      bit [NSRC-1:0] ev;
      ev = 0;
      if (softStartDone && overTemp) ev[0] = 1;
      for (int i = 0; i < NSW; i++)
        if (softStartDone && swLimit[i] && swCnt[i] >= 16) ev[1+i] = 1;
      for (int j = 0; j < NLDO; j++)
        if (softStartDone && ldoLimit[j] && ldoCnt[j] > 16) ev[LDO_BIT0+j] = 1;
      if (softStartDone && bypassMode && bypassOverTh) ev[NSRC-1] = 1;
      for (int i = 0; i < NSW; i++)
        if (!(softStartDone && swLimit[i])) swCnt[i] = 0;
        else if (swCycleStb[i] && swCnt[i] < 16) swCnt[i]++;
      for (int j = 0; j < NLDO; j++)
        if (!(softStartDone && ldoLimit[j])) ldoCnt[j] = 0;
        else if (usTick && ldoCnt[j] < 17) ldoCnt[j]++;
      mSticky = (mSticky & ~clearWr) | ev;
      if (cfgWr) begin mIrqEn = cfgData[0]; mVinEn = cfgData[1]; end
      mUnder = vinUnder; mOver = vinOver;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    chk("R1", faultStat[0], mSticky[0]);
    chk("R2", faultStat[NSW:1], mSticky[NSW:1]);
    chk("R3", faultStat[LDO_BIT0 +: NLDO], mSticky[LDO_BIT0 +: NLDO]);
    chk("R4", faultStat[NSRC-1], mSticky[NSRC-1]);
    chk("R7", irqN, !(mIrqEn && (mSticky != 0)));
    chk("R8", {vinUnderStat, vinOverStat}, {mUnder, mOver});
    chk("R9", vinStatN, !(mVinEn && (mUnder || mOver)));
  endtask

  task automatic step(input int n = 1);
    repeat (n) begin
      @(posedge clk); #5;
      compareAll();
    end
  endtask

  task automatic pulseStb(input int idx, input int count);
    repeat (count) begin
      swCycleStb[idx] = 1; step(); swCycleStb[idx] = 0; step();
    end
  endtask

  task automatic pulseTick(input int count);
    repeat (count) begin
      usTick = 1; step(); usTick = 0; step(2);
    end
  endtask

  task automatic clearAll();
    clearWr = '1; step(); clearWr = '0; step();
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    rstN = 1;
    step();
    // R10 reset state
    chk("R10", faultStat, 0);
    chk("R10", {irqN, vinStatN}, 2'b11);

    // R5: all sources active during soft-start
    overTemp = 1; swLimit = '1; ldoLimit = '1; bypassMode = 1; bypassOverTh = 1;
    swCycleStb = '1; usTick = 1; step(20);
    swCycleStb = '0; usTick = 0;
    chk("R5", faultStat, 0);
    overTemp = 0; swLimit = 0; ldoLimit = 0; bypassOverTh = 0; bypassMode = 0;
    step();
    softStartDone = 1;
    step();
    chk("R5", faultStat, 0);

    // R1 over-temperature, masked interrupt
    overTemp = 1; step(); overTemp = 0; step();
    chk("R1", faultStat[0], 1);
    chk("R7", irqN, 1);
    cfgWr = 1; cfgData = 2'b01; step(); cfgWr = 0; step();
    chk("R7", irqN, 0);
    step(3);
    chk("R6", faultStat[0], 1);
    clearAll();
    chk("R6", faultStat, 0);
    chk("R7", irqN, 1);

    // R2: 15 strobes, drop, then 16 strobes
    swLimit[1] = 1; pulseStb(1, 15);
    swLimit[1] = 0; step();
    chk("R2", faultStat[2], 0);
    swLimit[1] = 1; pulseStb(1, 15);
    chk("R2", faultStat[2], 0);
    pulseStb(1, 1);
    chk("R2", faultStat[2], 1);
    swLimit[1] = 0; step();
    clearAll();

    // R3: 16 ticks not enough, 17 is
    ldoLimit[0] = 1; pulseTick(16);
    chk("R3", faultStat[LDO_BIT0], 0);
    ldoLimit[0] = 0; step();
    ldoLimit[0] = 1; pulseTick(17);
    chk("R3", faultStat[LDO_BIT0], 1);
    ldoLimit[0] = 0; step();
    clearAll();

    // R4 bypass qualification by mode
    bypassOverTh = 1; step(4); bypassOverTh = 0; step();
    chk("R4", faultStat[NSRC-1], 0);
    bypassMode = 1; bypassOverTh = 1; step(); bypassOverTh = 0; step();
    chk("R4", faultStat[NSRC-1], 1);

    // R6: set and clear in the same cycle, event wins
    clearWr = '1; bypassOverTh = 1; step(); clearWr = '0; bypassOverTh = 0; step();
    chk("R6", faultStat[NSRC-1], 1);
    bypassMode = 0; clearAll();

    // R8/R9 voltage window
    vinUnder = 1; step(2);
    chk("R8", vinUnderStat, 1);
    chk("R9", vinStatN, 1);
    cfgWr = 1; cfgData = 2'b10; step(); cfgWr = 0; step();
    chk("R9", vinStatN, 0);
    vinUnder = 0; vinOver = 1; step(2);
    chk("R9", vinStatN, 0);
    vinOver = 0; step(2);
    chk("R9", vinStatN, 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule